// File: doc/BRIEF.md
# Delayed-Parity Command Checker

This block guards a registered command/address path against corruption. Each
clock it captures a 22-bit command word together with two active-low chip
selects. The matching parity bit reaches the block one clock after the word.
The block then checks the word against that late parity bit. When the check
fails it raises an error flag and holds it long enough for a memory controller
to catch it.

The flag is an active-high pull-down enable. It drives an active-low,
wired-AND error line, so the outputs of several checkers can share one line
that has a pull-up. Words captured while neither chip select is asserted are
not checked. An asynchronous reset releases the line at once. A short quiet
window after reset keeps a false error off the line while the input
receivers settle.

Top module: `cmd_parity_checker`

## Requirements
- R1: The check uses odd parity over all 22 data bits. The parity bit is the late `par_in`. If the number of ones in the word plus `par_in` is odd, the word is clean. If it is even, an error is flagged.
- R2: The parity for a word captured at clock edge m is the value of `par_in` sampled at edge m+1. `par_in` at edge m is not used for that word.
- R3: A word is checked only when at least one chip select bit in `cs_n` was 0 at its capture edge. A word captured with `cs_n` = 2'b11 never raises the flag. Such a word leaves the flag following earlier errors only.
- R4: For a failing word captured at edge m, `err_pull` goes to 1 on edge m+2.
- R5: A single error keeps `err_pull` at 1 for exactly two clock cycles, that is after edges m+2 and m+3. It then returns to 0.
- R6: An error found while `err_pull` is already 1 restarts the two-cycle hold. Errors on consecutive words therefore give one continuous pulse, which ends two cycles after the last error's first cycle.
- R7: While `rst_n` is 0, `err_pull` is 0. Asserting `rst_n` drops `err_pull` to 0 at once, without waiting for a clock edge.
- R8: After `rst_n` goes to 1, `err_pull` stays 0 for the first three clock edges. An error that would surface on any of those edges is discarded. A failing word captured on the second edge after release is reported on the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_data | input | 22 | Command/address word covered by parity |
| cs_n | input | 2 | Chip selects, active low; any 0 enables the check |
| par_in | input | 1 | Parity bit, one cycle later than its word |
| err_pull | output | 1 | 1 = pull the shared active-low error line low |

## Verification
The hardest state to reach is the boundary of the quiet window after reset. In that window one failing word must be discarded and the very next failing word must still be reported on time. The stimulus releases reset and drives two failing words back to back on the first two edges. It then expects the line to stay quiet for three edges and to be pulled for exactly the fourth and fifth. The table also interleaves gated words that carry wrong parity with checked words whose errors are isolated and whose errors are adjacent. This shows both the m+2 alignment and the hold restart.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  // Captured word summary passed from capture stage to compare stage
  typedef struct packed {
    logic valid;   // word was taken while a chip select was active
    logic dpar;    // XOR of all data bits of the word
  } cap_t;

endpackage

// File: rtl/cpc_capture.sv
module cpc_capture
  import cpc_pkg::*;
#(
  parameter int DATA_W = 22,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data,
  input  logic [NUM_CS-1:0] cs_n,
  output cap_t              cap_q
);

  // Any active chip select enables the check for this word
  logic [NUM_CS:0] sel_chain;
  assign sel_chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign sel_chain[g+1] = sel_chain[g] | ~cs_n[g];
  end

  // Data parity folded bit by bit
  logic [DATA_W:0] par_chain;
  assign par_chain[0] = 1'b0;
  for (genvar b = 0; b < DATA_W; b++) begin : g_par
    assign par_chain[b+1] = par_chain[b] ^ data[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else begin
      cap_q.valid <= sel_chain[NUM_CS];
      cap_q.dpar  <= par_chain[DATA_W];
    end
  end

endmodule

// File: rtl/cpc_compare.sv
module cpc_compare
  import cpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cap_t cap_q,
  input  logic par_in,
  output logic det_q
);

  // Odd parity: data ones plus late parity bit must be odd
  logic mismatch;
  assign mismatch = cap_q.valid & ~(cap_q.dpar ^ par_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_q <= 1'b0;
    else        det_q <= mismatch;
  end

endmodule

// File: rtl/cpc_stretch.sv
module cpc_stretch #(
  parameter int HOLD_CYC  = 2,
  parameter int QUIET_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_q,
  output logic pull_q
);

  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam logic [HW-1:0] HOLD_RELOAD = HW'(HOLD_CYC - 1);
  localparam logic [QW-1:0] QUIET_LOAD  = QW'(QUIET_CYC);

  logic [HW-1:0] hold_cnt;
  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= QUIET_LOAD;
      hold_cnt  <= '0;
      pull_q    <= 1'b0;
    end else if (quiet_cnt != '0) begin
      quiet_cnt <= quiet_cnt - 1'b1;
      hold_cnt  <= '0;
      pull_q    <= 1'b0;
    end else if (det_q) begin
      hold_cnt  <= HOLD_RELOAD;
      pull_q    <= 1'b1;
    end else if (hold_cnt != '0) begin
      hold_cnt  <= hold_cnt - 1'b1;
      pull_q    <= 1'b1;
    end else begin
      pull_q    <= 1'b0;
    end
  end

endmodule

// File: rtl/cmd_parity_checker.sv
module cmd_parity_checker
  import cpc_pkg::*;
#(
  parameter int DATA_W    = 22,
  parameter int NUM_CS    = 2,
  parameter int HOLD_CYC  = 2,
  parameter int QUIET_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [NUM_CS-1:0] cs_n,
  input  logic              par_in,
  output logic              err_pull
);

  cap_t cap_q;
  logic det_q;

  cpc_capture #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_cap (
    .clk(clk), .rst_n(rst_n), .data(cmd_data), .cs_n(cs_n), .cap_q(cap_q)
  );

  cpc_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .cap_q(cap_q), .par_in(par_in), .det_q(det_q)
  );

  cpc_stretch #(.HOLD_CYC(HOLD_CYC), .QUIET_CYC(QUIET_CYC)) u_str (
    .clk(clk), .rst_n(rst_n), .det_q(det_q), .pull_q(err_pull)
  );

endmodule

// File: rtl/cmd_parity_checker_chk.sv
module cmd_parity_checker_chk #(
  parameter int DATA_W    = 22,
  parameter int NUM_CS    = 2,
  parameter int QUIET_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cmd_data,
  input logic [NUM_CS-1:0] cs_n,
  input logic              par_in,
  input logic              err_pull
);

  localparam int SW = $clog2(QUIET_CYC + 2) + 1;
  localparam logic [SW-1:0] SMAX = '1;

  // Edges seen since reset release, saturating
  logic [SW-1:0] since_rst;
  logic          ref_valid, ref_dpar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      ref_valid <= 1'b0;
      ref_dpar  <= 1'b0;
    end else begin
      if (since_rst != SMAX) since_rst <= since_rst + 1'b1;
      ref_valid <= (cs_n != '1);
      ref_dpar  <= ^cmd_data;
    end
  end

  // R7
  reset_release_chk: assert property (@(posedge clk) !rst_n |-> !err_pull);

  // R5
  min_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_pull) |-> $past(err_pull, 2));

  // R8
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= SW'(QUIET_CYC)) |-> !err_pull);

  // R4
  report_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !(ref_dpar ^ par_in) && since_rst >= SW'(QUIET_CYC - 1))
      |=> ##1 err_pull);

  // R6
  hold_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pull) |=> err_pull);

endmodule

bind cmd_parity_checker cmd_parity_checker_chk #(
  .DATA_W(DATA_W), .NUM_CS(NUM_CS), .QUIET_CYC(QUIET_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cs_n(cs_n),
  .par_in(par_in), .err_pull(err_pull)
);

// File: tb/test_cmd_parity_checker.sv
module test_cmd_parity_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] cmd_data = '0;
  logic [1:0]  cs_n = 2'b11;
  logic        par_in = 1'b0;
  logic        err_pull;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmd_parity_checker i_cmd_parity_checker (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cs_n(cs_n),
    .par_in(par_in), .err_pull(err_pull)
  );

  // Fields: cs_n[25:24], data[23:2], par_in[1], expected err_pull after edge[0]
  localparam logic [25:0] VEC [16] = '{
    {2'b10, 22'h000001, 1'b0, 1'b0},  // 0 checked word, one 1
    {2'b01, 22'h000003, 1'b0, 1'b0},  // 1 par for 0 ok
    {2'b11, 22'h3FFFFF, 1'b0, 1'b0},  // 2 par for 1 wrong
    {2'b00, 22'h000000, 1'b0, 1'b1},  // 3 gated word 2 ignored; err from 1
    {2'b11, 22'h000000, 1'b1, 1'b1},  // 4 par for 3 ok
    {2'b10, 22'h3FFFFF, 1'b1, 1'b0},  // 5
    {2'b10, 22'h000001, 1'b0, 1'b0},  // 6 par for 5 wrong
    {2'b11, 22'h000000, 1'b1, 1'b1},  // 7 par for 6 wrong
    {2'b11, 22'h000000, 1'b0, 1'b1},  // 8 restart
    {2'b11, 22'h000000, 1'b0, 1'b1},  // 9 gated bad parity ignored
    {2'b11, 22'h000000, 1'b0, 1'b0},  // 10
    {2'b11, 22'h000000, 1'b0, 1'b0},  // 11
    {2'b01, 22'h3FFFFF, 1'b0, 1'b0},  // 12 checked word, 22 ones
    {2'b11, 22'h000000, 1'b1, 1'b0},  // 13 par for 12 ok
    {2'b11, 22'h000000, 1'b0, 1'b0},  // 14
    {2'b11, 22'h000000, 1'b0, 1'b0}   // 15
  };

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: err_pull=%b expected %b", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive inputs, pass one rising edge, return at next falling edge
  task automatic apply(input logic [1:0] c, input logic [21:0] d, input logic p);
    cs_n = c; cmd_data = d; par_in = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(err_pull, 1'b0, "R7 reset state");

    // R8 quiet window: bad words at edges 1 and 2 after release
    rst_n = 1'b1;
    apply(2'b00, 22'h0, 1'b0);
    check(err_pull, 1'b0, "R8 edge1");
    apply(2'b00, 22'h0, 1'b0);
    check(err_pull, 1'b0, "R8 edge2");
    apply(2'b11, 22'h0, 1'b0);
    check(err_pull, 1'b0, "R8 edge3 discarded");
    apply(2'b11, 22'h0, 1'b0);
    check(err_pull, 1'b1, "R8 R4 edge4 reported");
    apply(2'b11, 22'h0, 1'b0);
    check(err_pull, 1'b1, "R5 second cycle");
    apply(2'b11, 22'h0, 1'b0);
    check(err_pull, 1'b0, "R5 end of pulse");
    apply(2'b11, 22'h0, 1'b0);

    // Table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][25:24], VEC[i][23:2], VEC[i][1]);
      check(err_pull, VEC[i][0], $sformatf("R1 R2 R3 R4 R5 R6 vector %0d", i));
    end

    // R7 asynchronous clear mid-pulse
    apply(2'b10, 22'h0, 1'b0);
    apply(2'b11, 22'h0, 1'b0);
    apply(2'b11, 22'h0, 1'b0);
    check(err_pull, 1'b1, "R4 pulse before async reset");
    #3 rst_n = 1'b0;
    #1 check(err_pull, 1'b0, "R7 async clear");
    @(negedge clk);
    check(err_pull, 1'b0, "R7 held in reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, err_pull=%b expected completion", err_pull);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule